// File: doc/BRIEF.md
# Cell Measurement and Balancing Sequencer

This block sets the time schedule for a series-cell monitor that watches five to ten cells. It runs from a base tick. A fixed number of ticks forms one measurement period. Each period opens with a short measurement window. During that window the block steps a shared threshold selector through five levels, one per tick, and latches a per-cell comparator vector on each step. The rest of the period is a balancing window. Balancing windows alternate between the even-numbered cells and the odd-numbered cells, so one full balancing cycle spans two periods.

At the end of each measurement window the block updates its outputs. These are the qualified overvoltage and undervoltage faults, the all-cells-released and charge-enable summaries, and the set of cells that need balancing. A one-cycle strobe tells the surrounding controller when to sample them. The overvoltage and undervoltage faults each have their own counter of consecutive failing periods, so a short excursion does not trip a fault. During the balancing window, each active cell of the current parity gets a shunt enable when three conditions hold: balancing is allowed, the balance threshold is valid, and that cell sits above the balance level.

Top module: `cell_balance_sequencer`

## Requirements
- R1: One measurement period is 128 ticks. `measWindow` is high for the first 5 ticks of the period and low for the remaining 123. Clock cycles with `tick` low leave the schedule unchanged.
- R2: During the measurement window, `levelSel` takes the values 0 to 4 in order, advancing by one per tick: 0 = undervoltage, 1 = undervoltage release, 2 = charge enable, 3 = overvoltage, 4 = balance. `cmpAbove[i]` means "cell i+1 is above the selected level" and is sampled on each of these ticks.
- R3: `measDone` is high for exactly one clock cycle: the cycle after the fifth measurement tick. All summary and fault outputs change only at that edge.
- R4: `balParity` is 0 in the first period after reset and toggles at every period boundary. Bit i of `shuntEn` belongs to cell i+1. Parity 0 serves the even-numbered cells (odd i); parity 1 serves the odd-numbered cells (even i).
- R5: Outside sleep and during the balancing window, `shuntEn[i]` is high exactly when all of these hold: cell i+1 is active, it is in the current parity group, it was above the balance level in the last measurement, `balEnable` is 1, and `balThreshValid` is 1.
- R6: If every active cell was above the balance level in the last measurement, all shunt enables are low.
- R7: All shunt enables are low during the measurement window and whenever `sleep` is 1.
- R8: `ovFault` rises at the end of the 32nd consecutive period in which some active cell was above the overvoltage level.
- R9: `uvFault` rises at the end of the 32nd consecutive period in which some active cell was not above the undervoltage level. Its counter is separate from the overvoltage counter.
- R10: A period with no failing cell returns that fault's count to zero and clears that fault.
- R11: `cellCount` (binary) selects the active cells 1..N. Values below 5 act as 5, and values above 10 act as 10. Comparator bits of inactive cells affect no output.
- R12: `uvRelOk` is 1 when every active cell was above the release level. `chargeOk` is 1 when no active cell was above the charge-enable level. Both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base time tick enable (32 ticks per delay unit) |
| cellCount | input | 4 | Number of series cells in use |
| cmpAbove | input | 10 | Per-cell comparator result against the selected level |
| balEnable | input | 1 | Balancing permitted (charger seen) |
| balThreshValid | input | 1 | Balance threshold is nonzero |
| sleep | input | 1 | Protector asleep; forces shunts off |
| measWindow | output | 1 | High during the measurement window |
| levelSel | output | 3 | Threshold level currently selected for comparison |
| measDone | output | 1 | One-cycle strobe after the measurement window |
| balParity | output | 1 | Cell parity served by the current balancing window |
| shuntEn | output | 10 | Per-cell balancing shunt enable |
| ovFault | output | 1 | Qualified overvoltage fault |
| uvFault | output | 1 | Qualified undervoltage fault |
| uvRelOk | output | 1 | All active cells above release level |
| chargeOk | output | 1 | No active cell above charge-enable level |

## Verification
The hardest states to reach from the ports are the qualification boundaries. One is the 31st failing period, where the fault must still be low. Another is a failing streak broken by a single clean period. The bench reaches both by modelling cell voltages and answering `levelSel` with the matching comparator vector on every tick. It then runs whole 128-tick periods back to back while counting them itself, so it can sample exactly one period short of the limit and exactly at it. The same voltage model lets a failing voltage sit on an inactive cell for more than 32 periods, which shows that the count ignores inactive cells.

// File: rtl/cellseq_pkg.sv
package cellseq_pkg;
  localparam int NUM_LEVELS = 5;

  typedef enum logic [2:0] {
    LVL_UV    = 3'd0,
    LVL_UVREL = 3'd1,
    LVL_CE    = 3'd2,
    LVL_OV    = 3'd3,
    LVL_BAL   = 3'd4
  } level_e;

  // control -> datapath strobes
  typedef struct packed {
    logic [NUM_LEVELS-1:0] capture;   // one-hot: latch comparator for level k
    logic                  periodEnd; // last measurement tick
  } seqStrobes_t;
endpackage

// File: rtl/cellseq_ctrl.sv
module cellseq_ctrl
  import cellseq_pkg::*;
#(
  parameter int BAL_TICKS = 123
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  output seqStrobes_t strobes,
  output logic        measWindow,
  output logic [2:0]  levelSel,
  output logic        balParity
);
  localparam int PERIOD = NUM_LEVELS + BAL_TICKS;
  localparam int PW     = $clog2(PERIOD);

  logic [PW-1:0] phase;
  logic          parity;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= '0;
      parity <= 1'b0;
    end else if (tick) begin
      if (phase == PW'(PERIOD - 1)) begin
        phase  <= '0;
        parity <= ~parity;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign measWindow = (phase < PW'(NUM_LEVELS));
  assign levelSel   = measWindow ? 3'(phase) : LVL_BAL;
  assign balParity  = parity;

  for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_cap
    assign strobes.capture[k] = tick && (phase == PW'(k));
  end
  assign strobes.periodEnd = tick && (phase == PW'(NUM_LEVELS - 1));
endmodule

// File: rtl/cellseq_qualcnt.sv
module cellseq_qualcnt #(
  parameter int QUAL_PERIODS = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic update,
  input  logic fail,
  output logic qualified
);
  localparam int CNTW = $clog2(QUAL_PERIODS + 1);

  logic [CNTW-1:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLen <= '0;
    end else if (update) begin
      if (!fail)                                runLen <= '0;
      else if (runLen != CNTW'(QUAL_PERIODS))   runLen <= runLen + 1'b1;
    end
  end

  assign qualified = (runLen == CNTW'(QUAL_PERIODS));
endmodule

// File: rtl/cellseq_datapath.sv
module cellseq_datapath
  import cellseq_pkg::*;
#(
  parameter int MAX_CELLS    = 10,
  parameter int MIN_CELLS    = 5,
  parameter int QUAL_PERIODS = 32,
  localparam int CW = $clog2(MAX_CELLS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobes_t          strobes,
  input  logic [MAX_CELLS-1:0] cmpAbove,
  input  logic [CW-1:0]        cellCount,
  input  logic                 measWindow,
  input  logic                 balParity,
  input  logic                 sleep,
  input  logic                 balEnable,
  input  logic                 balThreshValid,
  output logic [MAX_CELLS-1:0] shuntEn,
  output logic                 measDone,
  output logic                 ovFault,
  output logic                 uvFault,
  output logic                 uvRelOk,
  output logic                 chargeOk
);
  logic [CW-1:0]        effCount;
  logic [MAX_CELLS-1:0] activeMask;

  always_comb begin
    if (cellCount < CW'(MIN_CELLS))      effCount = CW'(MIN_CELLS);
    else if (cellCount > CW'(MAX_CELLS)) effCount = CW'(MAX_CELLS);
    else                                 effCount = cellCount;
  end

  for (genvar i = 0; i < MAX_CELLS; i++) begin : g_mask
    assign activeMask[i] = (CW'(i) < effCount);
  end

  // staged comparator results for levels captured before the last one
  logic [MAX_CELLS-1:0] stage [NUM_LEVELS-1];
  logic [MAX_CELLS-1:0] balVec;
  logic                 balAll;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_LEVELS - 1; k++) stage[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_LEVELS - 1; k++)
        if (strobes.capture[k]) stage[k] <= cmpAbove & activeMask;
    end
  end

  logic uvFailNow, ovFailNow;
  assign uvFailNow = |(~stage[LVL_UV] & activeMask);
  assign ovFailNow = |stage[LVL_OV];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      balVec   <= '0;
      balAll   <= 1'b0;
      uvRelOk  <= 1'b0;
      chargeOk <= 1'b0;
      measDone <= 1'b0;
    end else begin
      measDone <= strobes.periodEnd;
      if (strobes.periodEnd) begin
        balVec   <= cmpAbove & activeMask;
        balAll   <= &(cmpAbove | ~activeMask);
        uvRelOk  <= &(stage[LVL_UVREL] | ~activeMask);
        chargeOk <= ~|stage[LVL_CE];
      end
    end
  end

  cellseq_qualcnt #(.QUAL_PERIODS(QUAL_PERIODS)) u_ovQual (
    .clk(clk), .rstN(rstN), .update(strobes.periodEnd),
    .fail(ovFailNow), .qualified(ovFault));

  cellseq_qualcnt #(.QUAL_PERIODS(QUAL_PERIODS)) u_uvQual (
    .clk(clk), .rstN(rstN), .update(strobes.periodEnd),
    .fail(uvFailNow), .qualified(uvFault));

  logic balGate;
  assign balGate = !measWindow && !sleep && balEnable && balThreshValid && !balAll;

  // bit i is cell i+1; parity 0 serves even-numbered cells (odd i)
  for (genvar i = 0; i < MAX_CELLS; i++) begin : g_shunt
    logic inGroup;
    if (i % 2 == 1) begin : g_evenCell
      assign inGroup = ~balParity;
    end else begin : g_oddCell
      assign inGroup = balParity;
    end
    assign shuntEn[i] = balGate && inGroup && balVec[i];
  end
endmodule

// File: rtl/cell_balance_sequencer.sv
module cell_balance_sequencer
  import cellseq_pkg::*;
#(
  parameter int MAX_CELLS    = 10,
  parameter int MIN_CELLS    = 5,
  parameter int BAL_TICKS    = 123,
  parameter int QUAL_PERIODS = 32,
  localparam int CW = $clog2(MAX_CELLS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic [CW-1:0]        cellCount,
  input  logic [MAX_CELLS-1:0] cmpAbove,
  input  logic                 balEnable,
  input  logic                 balThreshValid,
  input  logic                 sleep,
  output logic                 measWindow,
  output logic [2:0]           levelSel,
  output logic                 measDone,
  output logic                 balParity,
  output logic [MAX_CELLS-1:0] shuntEn,
  output logic                 ovFault,
  output logic                 uvFault,
  output logic                 uvRelOk,
  output logic                 chargeOk
);
  seqStrobes_t strobes;

  cellseq_ctrl #(.BAL_TICKS(BAL_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .strobes(strobes),
    .measWindow(measWindow), .levelSel(levelSel), .balParity(balParity));

  cellseq_datapath #(
    .MAX_CELLS(MAX_CELLS), .MIN_CELLS(MIN_CELLS), .QUAL_PERIODS(QUAL_PERIODS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmpAbove(cmpAbove),
    .cellCount(cellCount), .measWindow(measWindow), .balParity(balParity),
    .sleep(sleep), .balEnable(balEnable), .balThreshValid(balThreshValid),
    .shuntEn(shuntEn), .measDone(measDone), .ovFault(ovFault),
    .uvFault(uvFault), .uvRelOk(uvRelOk), .chargeOk(chargeOk));
endmodule

// File: rtl/cell_balance_sequencer_chk.sv
module cell_balance_sequencer_chk #(
  parameter int MAX_CELLS = 10,
  parameter int MIN_CELLS = 5,
  localparam int CW = $clog2(MAX_CELLS + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [CW-1:0]        cellCount,
  input logic                 sleep,
  input logic                 measWindow,
  input logic                 measDone,
  input logic                 balParity,
  input logic [MAX_CELLS-1:0] shuntEn,
  input logic                 ovFault,
  input logic                 uvFault
);
  logic [MAX_CELLS-1:0] liveCells;
  logic [MAX_CELLS-1:0] evenNumbered;

  always_comb begin
    int n;
    n = int'(cellCount);
    if (n < MIN_CELLS) n = MIN_CELLS;
    if (n > MAX_CELLS) n = MAX_CELLS;
    for (int i = 0; i < MAX_CELLS; i++) begin
      liveCells[i]    = (i < n);
      evenNumbered[i] = (((i + 1) % 2) == 0);
    end
  end

  assert_quiet_in_meas_R7: assert property (@(posedge clk) disable iff (!rstN)
    measWindow |-> (shuntEn == '0));

  assert_quiet_in_sleep_R7: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> (shuntEn == '0));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    measDone |=> !measDone);

  assert_done_after_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    measDone |-> (!measWindow && $past(measWindow)));

  assert_parity_group_R4: assert property (@(posedge clk) disable iff (!rstN)
    (shuntEn & (balParity ? evenNumbered : ~evenNumbered)) == '0);

  assert_inactive_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (shuntEn & ~liveCells) == '0);

  assert_ov_rise_at_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovFault) |-> measDone);

  assert_uv_rise_at_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uvFault) |-> measDone);
endmodule

bind cell_balance_sequencer cell_balance_sequencer_chk #(
  .MAX_CELLS(MAX_CELLS), .MIN_CELLS(MIN_CELLS)
) chk (
  .clk(clk), .rstN(rstN), .cellCount(cellCount), .sleep(sleep),
  .measWindow(measWindow), .measDone(measDone), .balParity(balParity),
  .shuntEn(shuntEn), .ovFault(ovFault), .uvFault(uvFault));

// File: tb/cell_balance_sequencer_test.sv
module cell_balance_sequencer_test;
  localparam int NC = 10;
  localparam int LV_UV = 2300, LV_REL = 2800, LV_CE = 4150, LV_OV = 4300, LV_BAL = 4100;

  logic clk = 0;
  logic rstN = 0, tick = 0;
  logic [3:0] cellCount = 4'd10;
  logic [NC-1:0] cmpAbove = '0;
  logic balEnable = 1, balThreshValid = 1, sleep = 0;
  logic measWindow, measDone, balParity, ovFault, uvFault, uvRelOk, chargeOk;
  logic [2:0] levelSel;
  logic [NC-1:0] shuntEn;

  int volt [NC];
  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cell_balance_sequencer uut (
    .clk(clk), .rstN(rstN), .tick(tick), .cellCount(cellCount),
    .cmpAbove(cmpAbove), .balEnable(balEnable), .balThreshValid(balThreshValid),
    .sleep(sleep), .measWindow(measWindow), .levelSel(levelSel),
    .measDone(measDone), .balParity(balParity), .shuntEn(shuntEn),
    .ovFault(ovFault), .uvFault(uvFault), .uvRelOk(uvRelOk), .chargeOk(chargeOk));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int levelOf(logic [2:0] sel);
    case (sel)
      3'd0: return LV_UV;
      3'd1: return LV_REL;
      3'd2: return LV_CE;
      3'd3: return LV_OV;
      default: return LV_BAL;
    endcase
  endfunction

  function automatic int effCells();
    int n = int'(cellCount);
    if (n < 5) n = 5;
    if (n > 10) n = 10;
    return n;
  endfunction

  function automatic logic [NC-1:0] expShunt(int par);
    logic [NC-1:0] r = '0;
    bit allAbove = 1;
    int n = effCells();
    for (int i = 0; i < n; i++) if (volt[i] <= LV_BAL) allAbove = 0;
    if (allAbove || !balEnable || !balThreshValid || sleep) return '0;
    for (int i = 0; i < n; i++)
      if (volt[i] > LV_BAL && (((i % 2) == 1) == (par == 0))) r[i] = 1'b1;
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runTicks(int n);
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      for (int i = 0; i < NC; i++) cmpAbove[i] = (volt[i] > levelOf(levelSel));
      tick = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic setAll(int v);
    for (int i = 0; i < NC; i++) volt[i] = v;
  endtask

  initial begin
    logic [NC-1:0] e;
    setAll(3700);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // reset state
    check(measWindow == 1, "R1", "reset measWindow", measWindow, 1);
    check(levelSel == 0, "R2", "reset levelSel", levelSel, 0);
    check(shuntEn == 0 && measDone == 0, "R3", "reset shunt/done", shuntEn, 0);
    check(ovFault == 0 && uvFault == 0, "R8", "reset faults", {ovFault, uvFault}, 0);
    check(uvRelOk == 0 && chargeOk == 0, "R12", "reset summaries", {uvRelOk, chargeOk}, 0);
    check(balParity == 0, "R4", "reset parity", balParity, 0);

    // no tick -> frozen
    repeat (3) @(negedge clk);
    check(levelSel == 0 && measWindow == 1, "R1", "frozen without tick", levelSel, 0);

    // level order
    for (int k = 0; k < 5; k++) begin
      check(levelSel == 3'(k), "R2", "level order", levelSel, k);
      runTicks(1);
    end
    check(measDone == 1, "R3", "strobe after window", measDone, 1);
    check(measWindow == 0, "R1", "balance window start", measWindow, 0);
    runTicks(1);
    check(measDone == 0, "R3", "strobe single cycle", measDone, 0);
    runTicks(121);
    check(measWindow == 0 && balParity == 0, "R1", "last tick of period", measWindow, 0);
    runTicks(1);
    check(measWindow == 1, "R1", "period length 128", measWindow, 1);
    check(balParity == 1, "R4", "parity toggles", balParity, 1);
    runTicks(128);

    // shunt sweep over cell counts and parities
    for (int cc = 3; cc <= 12; cc++) begin
      cellCount = 4'(cc);
      for (int i = 0; i < NC; i++) volt[i] = (((i + cc) % 3) == 0) ? 4200 : 3900;
      runTicks(5);
      e = expShunt(0);
      check(shuntEn == e, "R5", "even-cell shunts", shuntEn, e);
      check(balParity == 0, "R4", "even window", balParity, 0);
      runTicks(123);
      check(shuntEn == 0, "R7", "quiet in measurement", shuntEn, 0);
      runTicks(5);
      e = expShunt(1);
      check(shuntEn == e, "R11", "odd-cell shunts", shuntEn, e);
      runTicks(123);
    end

    // gating inputs
    cellCount = 4'd10;
    setAll(3900);
    volt[1] = 4200; volt[5] = 4200;
    runTicks(5);
    e = expShunt(0);
    check(shuntEn == e && e != 0, "R5", "gated reference", shuntEn, e);
    balEnable = 0; #1;
    check(shuntEn == 0, "R5", "balEnable low", shuntEn, 0);
    balEnable = 1; balThreshValid = 0; #1;
    check(shuntEn == 0, "R5", "threshold invalid", shuntEn, 0);
    balThreshValid = 1; sleep = 1; #1;
    check(shuntEn == 0, "R7", "sleep forces off", shuntEn, 0);
    sleep = 0; #1;
    check(shuntEn == e, "R5", "restored", shuntEn, e);
    runTicks(123);

    // all above balance level
    setAll(4200);
    runTicks(5);
    check(shuntEn == 0, "R6", "all above stops balancing", shuntEn, 0);
    check(chargeOk == 0 && uvRelOk == 1, "R12", "above ce level", {uvRelOk, chargeOk}, 2);
    runTicks(123);
    setAll(3700);
    runTicks(5);
    check(chargeOk == 1 && uvRelOk == 1, "R12", "nominal cells", {uvRelOk, chargeOk}, 3);
    runTicks(123);
    volt[3] = 2600;
    runTicks(5);
    check(uvRelOk == 0 && chargeOk == 1 && uvFault == 0, "R12", "below release", {uvRelOk, chargeOk}, 1);
    runTicks(123);
    volt[3] = 3700;

    // overvoltage qualification
    volt[2] = 4400;
    for (int p = 0; p < 31; p++) runTicks(128);
    check(ovFault == 0, "R8", "31 periods not yet", ovFault, 0);
    runTicks(5);
    check(ovFault == 1, "R8", "32nd period trips", ovFault, 1);
    check(uvFault == 0, "R9", "uv counter separate", uvFault, 0);
    runTicks(123);
    volt[2] = 3700;
    runTicks(5);
    check(ovFault == 0, "R10", "clean period clears ov", ovFault, 0);
    runTicks(123);

    // broken streak
    volt[2] = 4400;
    for (int p = 0; p < 20; p++) runTicks(128);
    volt[2] = 3700;
    runTicks(128);
    volt[2] = 4400;
    for (int p = 0; p < 31; p++) runTicks(128);
    check(ovFault == 0, "R10", "streak restarted", ovFault, 0);
    runTicks(5);
    check(ovFault == 1, "R8", "restarted streak trips", ovFault, 1);
    runTicks(123);
    volt[2] = 3700;
    runTicks(128);

    // inactive cell low is ignored
    cellCount = 4'd5;
    volt[8] = 2000;
    for (int p = 0; p < 33; p++) runTicks(128);
    check(uvFault == 0, "R11", "inactive cell ignored", uvFault, 0);
    check(uvRelOk == 1, "R11", "inactive cell release", uvRelOk, 1);
    volt[8] = 3700;

    // undervoltage qualification
    volt[1] = 2000;
    for (int p = 0; p < 31; p++) runTicks(128);
    check(uvFault == 0, "R9", "31 periods not yet", uvFault, 0);
    runTicks(5);
    check(uvFault == 1, "R9", "32nd period trips", uvFault, 1);
    check(ovFault == 0, "R9", "ov stays clear", ovFault, 0);
    runTicks(123);
    volt[1] = 3700;
    runTicks(5);
    check(uvFault == 0, "R10", "clean period clears uv", uvFault, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule